// File: doc/BRIEF.md
# Page Write Load Controller

This block is the write front end of a page-organised nonvolatile memory. It is modelled as synchronous logic. A host drives a parallel bus with an active-low select, an active-low write strobe, an active-low read enable, an address and a data byte. The block samples these pins on a system clock. A write strobe is active while select and write are both low. Each write strobe loads one byte into a page buffer. The address is taken when the strobe becomes active, which is the later of the two falling edges. The data is taken when the strobe ends, which is the first of the two rising edges. The upper address bits name the page and the low `OFS_W` bits name the byte within it.

The load phase has no explicit end command; it ends when the bus goes quiet. Each further byte must begin within a load window measured from the start of the previous accepted strobe. Once no data has arrived for the idle timeout and the strobes are inactive, the block starts an internal program phase of fixed length by itself. That phase first erases every loaded byte to all ones and, at its end, writes the buffered bytes into a behavioural array. Bytes of the page that were not loaded are left as they were. A busy pull-down is driven from the first strobe of an operation until programming ends. An active-low hold input aborts any operation and blocks reads and loads. Every window is given in nanoseconds and converted to clock cycles through a clock-frequency parameter.

The controller has four states. `ST_IDLE` goes to `ST_LOAD` on the first strobe. `ST_LOAD` goes to `ST_GAP` when the strobe ends. `ST_GAP` goes back to `ST_LOAD` on a strobe inside the window, or goes to `ST_PROG` on idle timeout. `ST_PROG` goes to `ST_IDLE` when the program length has elapsed. A low hold input forces `ST_IDLE` from any state.

Top module: `page_write_ctrl`

## Requirements
- R1: After system reset the busy pull-down, the read-data enable and the mismatch error are all 0, and every array byte reads 0xFF.
- R2: With hold high, no operation running, select low, read low and write high, the byte at the address appears on the read data with the enable at 1. With read high, the enable stays at 0.
- R3: A write strobe is active while select and write are both low. The address is taken at strobe start and the data at strobe end. The page is address bits [ADDR_W-1:OFS_W] and the byte offset is bits [OFS_W-1:0]. This holds whether the write line or the select line is the last to fall.
- R4: A further strobe is accepted only if it starts less than the load window after the start of the previous accepted strobe. A later strobe is ignored: its byte is not stored and the timers are not restarted.
- R5: The program phase begins only once the idle timeout has passed since the last data capture with the strobes inactive. Before that, nothing in the array has changed.
- R6: The program phase lasts exactly the program length in cycles. At its end every loaded byte holds the data last loaded for it and the busy pull-down is released.
- R7: Bytes not loaded in an operation, including all bytes of other pages, keep their previous contents.
- R8: The busy pull-down is 1 from the first strobe of an operation until the end of its program phase.
- R9: A strobe whose page differs from the first page of the operation stores nothing and sets the mismatch error. The error stays set until system reset.
- R10: While hold is low, reads give enable 0 and strobes start nothing. Hold going low during a program phase releases busy and leaves the loaded bytes erased to 0xFF. Hold going low before the program phase leaves the array unchanged.
- R11: An operation accepts from 1 up to all 2^OFS_W byte loads. Loading the same offset twice keeps the later data.
- R12: The read-data enable is never 1 while the busy pull-down is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| dev_hold_n | input | 1 | Active-low hold; aborts and blocks the device |
| bus_sel_n | input | 1 | Active-low device select |
| bus_wr_n | input | 1 | Active-low write line |
| bus_rd_n | input | 1 | Active-low read enable |
| bus_addr | input | ADDR_W | Byte address (page and offset) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, zero when not enabled |
| bus_rdata_en | output | 1 | Read data is being driven |
| busy_pull | output | 1 | 1 = busy line pulled low |
| page_mismatch_err | output | 1 | Sticky page-mismatch error |

## Verification
A wrong state here usually shows up late. A load that is dropped or captured twice shows only as an array byte that differs from expectation on the read sweep after programming. A wrong window or timeout shifts the release of the busy pull-down by many cycles, and the bench checks that release to within a few cycles. An abort in the wrong state gives either unchanged or 0xFF bytes in place of the other, and this shows on the first read after hold is released. A wrong busy or error flag shows at once at the ports.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_GAP  = 2'd2,
        ST_PROG = 2'd3
    } pgw_state_e;

    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
        longint unsigned c;
        c = (longint'(ns) * longint'(mhz)) / 1000;
        if (c < 2) c = 2;
        return int'(c);
    endfunction

endpackage

// File: rtl/pgw_sync.sv
module pgw_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pgw_timers.sv
module pgw_timers #(
    parameter int unsigned WIN_CYC  = 40,
    parameter int unsigned IDLE_CYC = 100,
    parameter int unsigned PROG_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_win,
    input  logic clr_idle,
    input  logic clr_prog,
    output logic win_open,
    output logic idle_done,
    output logic prog_done
);
    localparam int WIN_W  = $clog2(WIN_CYC + 1);
    localparam int IDLE_W = $clog2(IDLE_CYC + 1);
    localparam int PROG_W = $clog2(PROG_CYC + 1);

    logic [WIN_W-1:0]  win_cnt;
    logic [IDLE_W-1:0] idle_cnt;
    logic [PROG_W-1:0] prog_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt  <= WIN_W'(WIN_CYC);
            idle_cnt <= IDLE_W'(IDLE_CYC);
            prog_cnt <= PROG_W'(PROG_CYC - 1);
        end else begin
            if (clr_win)                            win_cnt <= '0;
            else if (win_cnt != WIN_W'(WIN_CYC))    win_cnt <= win_cnt + 1'b1;

            if (clr_idle)                           idle_cnt <= '0;
            else if (idle_cnt != IDLE_W'(IDLE_CYC)) idle_cnt <= idle_cnt + 1'b1;

            if (clr_prog)                               prog_cnt <= '0;
            else if (prog_cnt != PROG_W'(PROG_CYC - 1)) prog_cnt <= prog_cnt + 1'b1;
        end
    end

    assign win_open  = (win_cnt < WIN_W'(WIN_CYC));
    assign idle_done = (idle_cnt >= IDLE_W'(IDLE_CYC - 1));
    assign prog_done = (prog_cnt == PROG_W'(PROG_CYC - 1));
endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 7
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clr,
    input  logic                                  wr,
    input  logic [OFS_W-1:0]                      wr_off,
    input  logic [DATA_W-1:0]                     wr_data,
    output logic [(1<<OFS_W)-1:0][DATA_W-1:0]     data,
    output logic [(1<<OFS_W)-1:0]                 valid
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            valid <= '0;
        end else begin
            if (clr) valid <= '0;
            if (wr) begin
                data[wr_off]  <= wr_data;
                valid[wr_off] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pgw_array.sv
module pgw_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int OFS_W  = 7
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  erase,
    input  logic                                  commit,
    input  logic [ADDR_W-OFS_W-1:0]               page,
    input  logic [(1<<OFS_W)-1:0]                 mask,
    input  logic [(1<<OFS_W)-1:0][DATA_W-1:0]     wdata,
    input  logic [ADDR_W-1:0]                     raddr,
    output logic [DATA_W-1:0]                     rdata
);
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int PAGE_SZ = 1 << OFS_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '1;
        end else if (erase || commit) begin
            for (int i = 0; i < PAGE_SZ; i++) begin
                if (mask[i]) mem[{page, OFS_W'(i)}] <= erase ? {DATA_W{1'b1}} : wdata[i];
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
    parameter int          ADDR_W  = 10,
    parameter int          DATA_W  = 8,
    parameter int          OFS_W   = 7,
    parameter int unsigned CLK_MHZ = 50,
    parameter int unsigned WIN_NS  = 30_000,
    parameter int unsigned IDLE_NS = 100_000,
    parameter int unsigned PROG_NS = 10_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_hold_n,
    input  logic              bus_sel_n,
    input  logic              bus_wr_n,
    input  logic              bus_rd_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rdata_en,
    output logic              busy_pull,
    output logic              page_mismatch_err
);
    import pgw_pkg::*;

    localparam int          PG_W     = ADDR_W - OFS_W;
    localparam int          PAGE_SZ  = 1 << OFS_W;
    localparam int unsigned WIN_CYC  = ns_to_cyc(WIN_NS,  CLK_MHZ);
    localparam int unsigned IDLE_CYC = ns_to_cyc(IDLE_NS, CLK_MHZ);
    localparam int unsigned PROG_CYC = ns_to_cyc(PROG_NS, CLK_MHZ);

    // synchronised bus
    logic hold_s, sel_s, wr_s, rd_s;
    logic [ADDR_W-1:0] addr_p;
    logic [DATA_W-1:0] wdata_p;

    pgw_sync #(.W(4), .STAGES(2), .RST_VAL(4'b1111)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({dev_hold_n, bus_sel_n, bus_wr_n, bus_rd_n}),
        .q({hold_s, sel_s, wr_s, rd_s})
    );

    pgw_sync #(.W(ADDR_W + DATA_W), .STAGES(2), .RST_VAL('0)) u_bus_sync (
        .clk(clk), .rst_n(rst_n),
        .d({bus_addr, bus_wdata}),
        .q({addr_p, wdata_p})
    );

    logic stb, stb_q, stb_fall, stb_rise;
    assign stb      = !sel_s && !wr_s;
    assign stb_fall = stb && !stb_q;
    assign stb_rise = !stb && stb_q;

    logic [PG_W-1:0]  page_p;
    logic [OFS_W-1:0] ofs_p;
    assign page_p = addr_p[ADDR_W-1:OFS_W];
    assign ofs_p  = addr_p[OFS_W-1:0];

    // state machine
    pgw_state_e state, nxt;
    logic win_open, idle_done, prog_done;
    logic [PG_W-1:0]  op_page;
    logic [OFS_W-1:0] cur_off;
    logic             drop;

    always_comb begin
        nxt = state;
        if (!hold_s) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (stb_fall) nxt = ST_LOAD;
                ST_LOAD: if (stb_rise) nxt = ST_GAP;
                ST_GAP: begin
                    if (stb_fall && win_open)   nxt = ST_LOAD;
                    else if (idle_done && !stb) nxt = ST_PROG;
                end
                ST_PROG: if (prog_done) nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transition strobes
    logic go_first, go_next, cap_done, go_prog, finish, mismatch, rd_ok;
    assign go_first = (state == ST_IDLE) && (nxt == ST_LOAD);
    assign go_next  = (state == ST_GAP)  && (nxt == ST_LOAD);
    assign cap_done = (state == ST_LOAD) && (nxt == ST_GAP);
    assign go_prog  = (state == ST_GAP)  && (nxt == ST_PROG);
    assign finish   = (state == ST_PROG) && (nxt == ST_IDLE) && hold_s;
    assign mismatch = (page_p != op_page);
    assign rd_ok    = hold_s && (state == ST_IDLE) && !sel_s && !rd_s && wr_s;

    // outputs and operation registers
    logic [DATA_W-1:0] rd_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q             <= 1'b0;
            op_page           <= '0;
            cur_off           <= '0;
            drop              <= 1'b0;
            busy_pull         <= 1'b0;
            page_mismatch_err <= 1'b0;
            bus_rdata         <= '0;
            bus_rdata_en      <= 1'b0;
        end else begin
            stb_q <= stb;
            if (!hold_s) begin
                busy_pull <= 1'b0;
            end else begin
                if (go_first) begin
                    op_page   <= page_p;
                    cur_off   <= ofs_p;
                    drop      <= 1'b0;
                    busy_pull <= 1'b1;
                end
                if (go_next) begin
                    cur_off <= ofs_p;
                    drop    <= mismatch;
                    if (mismatch) page_mismatch_err <= 1'b1;
                end
                if (finish) busy_pull <= 1'b0;
            end
            bus_rdata_en <= rd_ok;
            bus_rdata    <= rd_ok ? rd_data : '0;
        end
    end

    // datapath
    pgw_timers #(.WIN_CYC(WIN_CYC), .IDLE_CYC(IDLE_CYC), .PROG_CYC(PROG_CYC)) u_timers (
        .clk(clk), .rst_n(rst_n),
        .clr_win(go_first || go_next),
        .clr_idle(cap_done),
        .clr_prog(go_prog),
        .win_open(win_open),
        .idle_done(idle_done),
        .prog_done(prog_done)
    );

    logic [PAGE_SZ-1:0][DATA_W-1:0] buf_data;
    logic [PAGE_SZ-1:0]             buf_valid;

    pgw_page_buf #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .clr(go_first),
        .wr(cap_done && !drop),
        .wr_off(cur_off),
        .wr_data(wdata_p),
        .data(buf_data),
        .valid(buf_valid)
    );

    pgw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .erase(go_prog),
        .commit(finish),
        .page(op_page),
        .mask(buf_valid),
        .wdata(buf_data),
        .raddr(addr_p),
        .rdata(rd_data)
    );
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
    parameter int unsigned PROG_CYC = 200
) (
    input logic clk,
    input logic rst_n,
    input logic res_n,
    input logic res_s,
    input logic in_prog,
    input logic in_op,
    input logic busy_pull,
    input logic rdata_en,
    input logic err
);
    int unsigned prog_run;

    always_ff @(posedge clk) begin
        if (!rst_n)       prog_run <= 0;
        else if (in_prog) prog_run <= prog_run + 1;
        else              prog_run <= 0;
    end

    AST_BUSY_DURING_OP: assert property (@(posedge clk) disable iff (!rst_n)
        in_op |-> busy_pull);  // R8

    AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_pull |-> !rdata_en);  // R12

    AST_HOLD_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!res_n, 1) && $past(!res_n, 2) && $past(!res_n, 3)) |-> (!busy_pull && !rdata_en));  // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err) |-> err);  // R9

    AST_PROG_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_pull) && $past(res_s)) |-> (prog_run == PROG_CYC));  // R6
endmodule

bind page_write_ctrl pgw_checker #(.PROG_CYC(PROG_CYC)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .res_n(dev_hold_n),
    .res_s(hold_s),
    .in_prog(state == ST_PROG),
    .in_op(state != ST_IDLE),
    .busy_pull(busy_pull),
    .rdata_en(bus_rdata_en),
    .err(page_mismatch_err)
);

// File: tb/page_write_ctrl_tb.sv
module page_write_ctrl_tb;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int OW = 7;
    localparam int WIN  = 40;
    localparam int IDLE = 100;
    localparam int PROG = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_n = 1'b1, sel_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic rdata_en, busy, err;

    always #2.5 clk = ~clk;

    page_write_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .OFS_W(OW), .CLK_MHZ(200),
        .WIN_NS(200), .IDLE_NS(500), .PROG_NS(1000)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .dev_hold_n(hold_n),
        .bus_sel_n(sel_n), .bus_wr_n(wr_n), .bus_rd_n(rd_n),
        .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .bus_rdata_en(rdata_en),
        .busy_pull(busy), .page_mismatch_err(err)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    int cyc     = 0;
    logic [DW-1:0] exp_mem [1 << AW];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one byte load; ce_ctl selects which line falls last and rises first
    task automatic load_byte(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit ce_ctl);
        addr = a; wdata = d;
        if (ce_ctl) wr_n = 1'b0; else sel_n = 1'b0;
        @(negedge clk);
        if (ce_ctl) sel_n = 1'b0; else wr_n = 1'b0;
        repeat (3) @(negedge clk);
        if (ce_ctl) sel_n = 1'b1; else wr_n = 1'b1;
        repeat (2) @(negedge clk);
        if (ce_ctl) wr_n = 1'b1; else sel_n = 1'b1;
    endtask

    task automatic read_byte(input logic [AW-1:0] a, input bit use_rd,
                             output logic [DW-1:0] d, output logic en);
        addr = a; sel_n = 1'b0; rd_n = use_rd ? 1'b0 : 1'b1;
        repeat (5) @(negedge clk);
        d = rdata; en = rdata_en;
        sel_n = 1'b1; rd_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_free(output int delta);
        int mark;
        int k;
        mark = cyc; k = 0;
        while (busy && k < 3000) begin @(negedge clk); k++; end
        delta = cyc - mark;
        chk(!busy, "R6 busy release", busy, 0);
    endtask

    task automatic sweep(input int lo, input int hi, input string req);
        logic [DW-1:0] d;
        logic en;
        for (int a = lo; a < hi; a++) begin
            read_byte(AW'(a), 1'b1, d, en);
            chk(en && d == exp_mem[a], req, {en, d}, {1'b1, exp_mem[a]});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic en;
        int dl;
        for (int a = 0; a < (1 << AW); a++) exp_mem[a] = 8'hFF;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        gap(4);
        // R1 reset state
        chk(!busy, "R1 busy after reset", busy, 0);
        chk(!rdata_en, "R1 rdata_en after reset", rdata_en, 0);
        chk(!err, "R1 err after reset", err, 0);
        sweep(0, 256, "R1 erased array");
        // R2 read with read line high gives no data
        read_byte(10'd3, 1'b0, d, en);
        chk(!en, "R2 no read with rd high", en, 0);

        // Op A: page 2, write-line controlled, repeated offset (R3 R11)
        load_byte(10'd261, 8'h10, 1'b0); gap(8);
        chk(busy, "R8 busy after first strobe", busy, 1);
        load_byte(10'd262, 8'h20, 1'b0); gap(8);
        load_byte(10'd263, 8'h30, 1'b0); gap(8);
        load_byte(10'd262, 8'h44, 1'b0);
        begin
            int mark;
            mark = cyc;
            read_byte(10'd261, 1'b1, d, en);
            chk(!en, "R12 no read while busy", en, 0);
            wait_free(dl);
            dl = dl + (cyc - mark) - dl;
            chk(dl >= IDLE + PROG - 4 && dl <= IDLE + PROG + 8, "R5 R6 idle+program timing", dl, IDLE + PROG);
        end
        exp_mem[261] = 8'h10; exp_mem[262] = 8'h44; exp_mem[263] = 8'h30;
        sweep(256, 384, "R3 R7 R11 page 2 contents");

        // Op B: full page 5 with select-line control (R3 R11)
        for (int i = 0; i < (1 << OW); i++) begin
            load_byte(AW'(640 + i), DW'(i * 7 + 3), 1'b1);
            gap(2);
            exp_mem[640 + i] = DW'(i * 7 + 3);
        end
        wait_free(dl);
        sweep(640, 768, "R11 full page contents");

        // Op C: load window (R4)
        load_byte(10'd128, 8'h11, 1'b0); gap(24);
        load_byte(10'd130, 8'h22, 1'b0); gap(54);
        load_byte(10'd129, 8'h99, 1'b0);
        wait_free(dl);
        exp_mem[128] = 8'h11; exp_mem[130] = 8'h22;
        read_byte(10'd129, 1'b1, d, en);
        chk(en && d == 8'hFF, "R4 late strobe ignored", d, 8'hFF);
        read_byte(10'd130, 1'b1, d, en);
        chk(en && d == 8'h22, "R4 in-window strobe stored", d, 8'h22);

        // Op D: page mismatch (R9)
        load_byte(10'd394, 8'h33, 1'b0); gap(8);
        load_byte(10'd522, 8'h44, 1'b0); gap(2);
        chk(err, "R9 mismatch flag set", err, 1);
        gap(6);
        load_byte(10'd395, 8'h55, 1'b0);
        wait_free(dl);
        exp_mem[394] = 8'h33; exp_mem[395] = 8'h55;
        sweep(384, 528, "R9 R7 mismatch contents");

        // Op E0: known content on page 6
        load_byte(10'd768, 8'h5A, 1'b0);
        wait_free(dl);
        exp_mem[768] = 8'h5A;

        // Op E: hold before the program phase (R5 R10)
        load_byte(10'd768, 8'hA5, 1'b0);
        gap(IDLE - 15);
        hold_n = 1'b0; gap(4);
        read_byte(10'd768, 1'b1, d, en);
        chk(!en, "R10 read blocked under hold", en, 0);
        load_byte(10'd769, 8'h77, 1'b0); gap(2);
        hold_n = 1'b1; gap(10);
        chk(!busy, "R10 strobe under hold starts nothing", busy, 0);
        read_byte(10'd768, 1'b1, d, en);
        chk(en && d == 8'h5A, "R5 hold before program leaves array", d, 8'h5A);
        read_byte(10'd769, 1'b1, d, en);
        chk(en && d == 8'hFF, "R10 load under hold ignored", d, 8'hFF);

        // Op F: hold during the program phase (R10)
        load_byte(10'd768, 8'hC3, 1'b0);
        gap(IDLE + 30);
        chk(busy, "R8 busy in program phase", busy, 1);
        hold_n = 1'b0; gap(6);
        chk(!busy, "R10 hold releases busy", busy, 0);
        hold_n = 1'b1; gap(6);
        exp_mem[768] = 8'hFF;
        read_byte(10'd768, 1'b1, d, en);
        chk(en && d == 8'hFF, "R10 aborted byte left erased", d, 8'hFF);

        // full array sweep and sticky error
        sweep(0, 1 << AW, "R7 final array");
        chk(err, "R9 error still set", err, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule